// File: doc/BRIEF.md
# Interframe Gap Countdown Timer

This block keeps a minimum gap, measured in bit times, between frames sent by a serial link controller. The same timer serves contention-based (CSMA/CD) operation and synchronous bit-oriented (SDLC) operation. The CPU writes the gap as an 8-bit number of bit times. Only even gaps are supported, so the block keeps the written value divided by two as a 7-bit reload value. A gap is built by counting that reload value down to zero twice.

An end-of-frame pulse in the CPU clock domain starts a gap. The counter runs in the bit clock domain and steps once per bit-time strobe. While a gap runs, the transmit-permit output is low. It goes high again when the second countdown reaches zero.

A read returns the live count in bits [7:1] and a pass flag in bit [0]. The flag is 1 during the first countdown and 0 during the second. The readback comes straight from the bit clock domain, so a CPU read has no coherency guarantee. Writes and end-of-frame events cross into the bit clock domain as toggles through two-flop synchronizers.

Top module: `ifs_gap_timer`

## Requirements
- R1: After reset, tx_permit is 1 and rd_data is 0.
- R2: For a written value W, tx_permit stays low for exactly 2*floor(W/2) bit strobes (cycles with bit_stb high) after an end-of-frame. Cycles with bit_stb low do not advance the count.
- R3: The LSB of a written value is discarded. A write of 7 gives the same gap as a write of 6.
- R4: rd_data[7:1] is the live count and rd_data[0] is the pass flag (1 = first pass, 0 = second pass). With H = floor(W/2) and k strobes consumed in the gap, rd_data reads {H-k, 1} for k < H and {2H-k, 0} for H <= k < 2H.
- R5: An end-of-frame makes tx_permit go low and loads the count. The first readback of the gap is {H, 1}.
- R6: When H is 0, an end-of-frame leaves tx_permit high and rd_data at 0.
- R7: A write made during a gap does not change that gap. The new value applies from the next end-of-frame.
- R8: The largest written value, 255, produces a gap of 254 strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | CPU-side clock |
| bit_clk | input | 1 | Bit-time domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | Write strobe for the gap value (cpu_clk) |
| wr_data | input | 8 | Gap in bit times; the LSB is dropped |
| eof_pulse | input | 1 | One-cycle end-of-frame pulse (cpu_clk) that starts a gap |
| bit_stb | input | 1 | One bit time elapsed (bit_clk) |
| rd_data | output | 8 | {live count, pass flag} |
| tx_permit | output | 1 | High when a new frame may be sent |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a running gap. The bench has to prove that the write changes neither the current reload nor the second pass. To get there, a gap is started with a small value, and a parallel thread in the CPU domain issues a new write while the bit domain is still counting. The readback is compared against the strobe count on every bit clock. Then the next gap is checked for the new length.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  localparam int unsigned DEF_HALF_W = 7;
  typedef enum logic {
    PASS_SECOND = 1'b0,
    PASS_FIRST  = 1'b1
  } pass_e;
endpackage

// File: rtl/ifs_rst_sync.sv
module ifs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/ifs_sync2.sv
module ifs_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/ifs_cpu_port.sv
module ifs_cpu_port #(
  parameter int unsigned HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [HALF_W-1:0] wr_half,
  input  logic              eof_pulse,
  output logic [HALF_W-1:0] half_q,
  output logic              wr_tgl_q,
  output logic              eof_tgl_q
);
  logic [HALF_W-1:0] half_n;
  logic              wr_tgl_n;
  logic              eof_tgl_n;

  always_comb begin
    half_n    = half_q;
    wr_tgl_n  = wr_tgl_q;
    eof_tgl_n = eof_tgl_q;
    if (wr_en) begin
      half_n   = wr_half;
      wr_tgl_n = ~wr_tgl_q;
    end
    if (eof_pulse) eof_tgl_n = ~eof_tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q    <= '0;
      wr_tgl_q  <= 1'b0;
      eof_tgl_q <= 1'b0;
    end else begin
      half_q    <= half_n;
      wr_tgl_q  <= wr_tgl_n;
      eof_tgl_q <= eof_tgl_n;
    end
  end

  // R7
  wr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_tgl_q != $past(wr_tgl_q)));
endmodule

// File: rtl/ifs_gap_counter.sv
module ifs_gap_counter
  import ifs_pkg::*;
#(
  parameter int unsigned HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_tgl_s,
  input  logic              eof_tgl_s,
  input  logic [HALF_W-1:0] half_in,
  input  logic              bit_stb,
  output logic [HALF_W-1:0] cnt_q,
  output pass_e             pass_q,
  output logic              busy_q
);
  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  logic              wr_d_q, eof_d_q;
  logic [HALF_W-1:0] shadow_q, shadow_n;
  logic [HALF_W-1:0] act_q, act_n;
  logic [HALF_W-1:0] cnt_n;
  pass_e             pass_n;
  logic              busy_n;
  logic              wr_evt, eof_evt;

  assign wr_evt  = wr_tgl_s ^ wr_d_q;
  assign eof_evt = eof_tgl_s ^ eof_d_q;

  always_comb begin
    shadow_n = shadow_q;
    act_n    = act_q;
    cnt_n    = cnt_q;
    pass_n   = pass_q;
    busy_n   = busy_q;
    if (wr_evt) shadow_n = half_in;
    if (eof_evt) begin
      act_n = shadow_q;
      cnt_n = shadow_q;
      if (shadow_q != '0) begin
        busy_n = 1'b1;
        pass_n = PASS_FIRST;
      end else begin
        busy_n = 1'b0;
        pass_n = PASS_SECOND;
      end
    end else if (busy_q && bit_stb) begin
      if (cnt_q == ONE) begin
        if (pass_q == PASS_FIRST) begin
          cnt_n  = act_q;
          pass_n = PASS_SECOND;
        end else begin
          cnt_n  = '0;
          busy_n = 1'b0;
        end
      end else begin
        cnt_n = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_d_q   <= 1'b0;
      eof_d_q  <= 1'b0;
      shadow_q <= '0;
      act_q    <= '0;
      cnt_q    <= '0;
      pass_q   <= PASS_SECOND;
      busy_q   <= 1'b0;
    end else begin
      wr_d_q   <= wr_tgl_s;
      eof_d_q  <= eof_tgl_s;
      shadow_q <= shadow_n;
      act_q    <= act_n;
      cnt_q    <= cnt_n;
      pass_q   <= pass_n;
      busy_q   <= busy_n;
    end
  end

  // R4
  pass_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_q == PASS_FIRST) |-> busy_q);
  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0) && (cnt_q <= act_q));
  // R5
  eof_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_evt && shadow_q != '0) |=>
      (busy_q && pass_q == PASS_FIRST && cnt_q == $past(shadow_q)));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bit_stb && !eof_evt && cnt_q != ONE) |=> (cnt_q == $past(cnt_q) - ONE));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb && !eof_evt) |=> $stable(cnt_q));
  // R6
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (cnt_q == '0 && pass_q == PASS_SECOND));
endmodule

// File: rtl/ifs_gap_timer.sv
module ifs_gap_timer
  import ifs_pkg::*;
#(
  parameter int unsigned HALF_W = DEF_HALF_W,
  localparam int unsigned REG_W = HALF_W + 1
) (
  input  logic             cpu_clk,
  input  logic             bit_clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             eof_pulse,
  input  logic             bit_stb,
  output logic [REG_W-1:0] rd_data,
  output logic             tx_permit
);
  logic              cpu_rst_n, bit_rst_n;
  logic [HALF_W-1:0] half_q;
  logic              wr_tgl, eof_tgl;
  logic [1:0]        tgl_s;
  logic [HALF_W-1:0] cnt;
  pass_e             pass;
  logic              busy;
  logic              unused_lsb;

  assign unused_lsb = wr_data[0];

  ifs_rst_sync u_rst_cpu (.clk(cpu_clk), .arst_n(rst_n), .srst_n(cpu_rst_n));
  ifs_rst_sync u_rst_bit (.clk(bit_clk), .arst_n(rst_n), .srst_n(bit_rst_n));

  ifs_cpu_port #(.HALF_W(HALF_W)) u_cpu (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .wr_en(wr_en),
    .wr_half(wr_data[REG_W-1:1]), .eof_pulse(eof_pulse),
    .half_q(half_q), .wr_tgl_q(wr_tgl), .eof_tgl_q(eof_tgl)
  );

  ifs_sync2 #(.W(2)) u_sync (
    .clk(bit_clk), .rst_n(bit_rst_n), .d({eof_tgl, wr_tgl}), .q(tgl_s)
  );

  ifs_gap_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk(bit_clk), .rst_n(bit_rst_n), .wr_tgl_s(tgl_s[0]), .eof_tgl_s(tgl_s[1]),
    .half_in(half_q), .bit_stb(bit_stb),
    .cnt_q(cnt), .pass_q(pass), .busy_q(busy)
  );

  assign rd_data   = {cnt, pass};
  assign tx_permit = ~busy;
endmodule

// File: tb/sim_ifs_gap_timer.sv
module sim_ifs_gap_timer;
  logic       cpu_clk = 1'b0;
  logic       bit_clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       eof_pulse;
  logic       bit_stb = 1'b0;
  logic [7:0] rd_data;
  logic       tx_permit;
  int         n_run = 0;
  int         n_fail = 0;
  int         div = 0;

  always #5 cpu_clk = ~cpu_clk;
  always #7 bit_clk = ~bit_clk;

  // one strobe every third bit clock
  always @(negedge bit_clk) begin
    div     <= (div == 2) ? 0 : div + 1;
    bit_stb <= (div == 0);
  end

  ifs_gap_timer u0 (
    .cpu_clk(cpu_clk), .bit_clk(bit_clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .eof_pulse(eof_pulse), .bit_stb(bit_stb),
    .rd_data(rd_data), .tx_permit(tx_permit)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [7:0] v);
    @(negedge cpu_clk); wr_en = 1'b1; wr_data = v;
    @(negedge cpu_clk); wr_en = 1'b0;
    repeat (2) @(negedge cpu_clk);
  endtask

  task automatic fire_eof();
    @(negedge cpu_clk); eof_pulse = 1'b1;
    @(negedge cpu_clk); eof_pulse = 1'b0;
  endtask

  // Follows one gap, compares readback to strobes consumed, checks length.
  task automatic observe_gap(input int h, input string req);
    int   k = 0;
    int   bad = 0;
    int   first_rd = -1;
    logic pp = 1'b1;
    bit   started = 0;
    for (int g = 0; g < 5000; g++) begin
      @(negedge bit_clk);
      if (bit_stb && !pp) k++;
      if (!tx_permit) begin
        if (!started) first_rd = int'(rd_data);
        started = 1;
        if (k < h) begin
          if (rd_data != {7'(h - k), 1'b1}) begin
            bad++;
            $display("FAIL R4 first pass readback: actual %0d expected %0d",
                     rd_data, {7'(h - k), 1'b1});
          end
        end else if (rd_data != {7'(2 * h - k), 1'b0}) begin
          bad++;
          $display("FAIL R4 second pass readback: actual %0d expected %0d",
                   rd_data, {7'(2 * h - k), 1'b0});
        end
      end
      pp = tx_permit;
      if (started && tx_permit) break;
    end
    n_run++;
    n_fail += (bad != 0) ? 1 : 0;
    chk(first_rd == int'({7'(h), 1'b1}), "R5", "load readback", first_rd, int'({7'(h), 1'b1}));
    chk(k == 2 * h, req, "gap strobes", k, 2 * h);
    chk(rd_data == 8'h00, "R4", "idle readback", int'(rd_data), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; eof_pulse = 1'b0;
    repeat (4) @(negedge cpu_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge cpu_clk);
    chk(tx_permit == 1'b1, "R1", "permit after reset", int'(tx_permit), 1);
    chk(rd_data == 8'h00, "R1", "readback after reset", int'(rd_data), 0);
  endtask

  task automatic t_basic();
    cpu_write(8'd10); fire_eof(); observe_gap(5, "R2");
    cpu_write(8'd2);  fire_eof(); observe_gap(1, "R2");
  endtask

  task automatic t_odd();
    cpu_write(8'd7); fire_eof(); observe_gap(3, "R3");
  endtask

  task automatic t_zero();
    int bad = 0;
    cpu_write(8'd1); fire_eof();
    for (int i = 0; i < 40; i++) begin
      @(negedge bit_clk);
      if (!tx_permit || rd_data != 8'h00) bad++;
    end
    chk(bad == 0, "R6", "zero gap cycles with permit low or readback set", bad, 0);
  endtask

  task automatic t_write_mid_gap();
    cpu_write(8'd8); fire_eof();
    fork
      observe_gap(4, "R7");
      begin
        repeat (20) @(negedge cpu_clk);
        chk(tx_permit == 1'b0, "R7", "gap running at write", int'(tx_permit), 0);
        cpu_write(8'd20);
      end
    join
    fire_eof(); observe_gap(10, "R7");
  endtask

  task automatic t_max();
    cpu_write(8'd255); fire_eof(); observe_gap(127, "R8");
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_odd();
    t_zero();
    t_write_mid_gap();
    t_max();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule